// File: doc/BRIEF.md
# Single-Level Interrupt Controller with Return-Stack Guard

This block sits beside a small processor core and decides when the core should leave its current program flow to serve an interrupt. Three sources feed it: an external input line, a timer/event counter and an A/D converter. Each source owns a request flag and an enable bit, and a single master enable gates them all. Software reads and writes these bits as one control register over the data bus.

The block asks the core to take an interrupt while the master enable is set, at least one enabled flag is pending, and the core's return stack still has room. It also supplies the vector address of the winning source. When the core reports that the program counter has been pushed, the block clears the master enable, so a second interrupt cannot nest by default. It also clears the served source's flag. Requests that arrive while the master enable is clear are still latched and wait. A service routine may set the master enable again to allow nesting. A wake-up output tells a halted core that an enabled request is waiting, whatever the master enable holds.

Top module: `irq_guard_ctrl`

## Requirements
- R1: After reset, every control register bit reads 0, and `irq_take` and `wake` are low.
- R2: A register write loads the master enable from bit 0. It loads the enables of external, timer and A/D from bits 1, 2 and 3, and their request flags from bits 4, 5 and 6. The register reads back in the same layout, and bit 7 always reads 0.
- R3: A high level on `src_req[i]` at a clock edge sets that source's flag (index 0 external, 1 timer, 2 A/D), whatever the master enable and the source enable hold.
- R4: `irq_take` is high exactly when the master enable is set, at least one flag is pending with its enable set, and `stack_full` is low.
- R5: `irq_vector` names the highest-priority source whose flag and enable are both set: external 0x04, timer 0x08, A/D 0x0C. It reads 0x00 when no such source exists. The vector does not depend on the master enable or on `stack_full`.
- R6: An `irq_ack` while `irq_take` is high clears the master enable and the flag of the source named by `irq_vector`. All other bits are kept, and this takes priority over a register write in the same cycle.
- R7: An `irq_ack` while `irq_take` is low changes no register bit.
- R8: While `stack_full` is high, no interrupt is offered. Once it falls with an enabled request pending and the master enable set, `irq_take` rises in that same cycle.
- R9: `wake` is high exactly when some flag is set together with its enable, independent of the master enable and of `stack_full`.
- R10: A source request in the same cycle as an acknowledge or a write that would clear its flag wins, and the flag stays set.
- R11: After an acknowledge, writing the master enable back to 1 lets the next pending enabled source be offered with its own vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 3 | Request strobes: bit 0 external, 1 timer, 2 A/D |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| stack_full | input | 1 | Core return stack has no free entry |
| irq_ack | input | 1 | Core has pushed the program counter for the offered interrupt |
| irq_take | output | 1 | Interrupt offered to the core |
| irq_vector | output | 8 | Vector address of the selected source |
| wake | output | 1 | Wake-up request for a halted core |

## Verification
The hardest cases to reach are the cycles where several updates hit one flag at once: a source strobe that lands on the same edge as an acknowledge or as a clearing write, and an acknowledge that arrives while the return stack is full. The bench reaches them with directed sequences that drive the acknowledge and the source strobe in one cycle. It also holds `stack_full` high across an acknowledge, then lowers it and checks that the interrupt is offered at once. A chain of acknowledges, each followed by re-enabling the master bit, walks the priority order down from external to A/D.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Isolate the lowest set bit: index 0 has the highest priority.
  function automatic logic [31:0] lowest_one(input logic [31:0] mask);
    return mask & (~mask + 32'd1);
  endfunction

  // Vector address of source idx.
  function automatic int unsigned vec_addr(input int unsigned idx,
                                           input int unsigned base,
                                           input int unsigned step);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_ack,
  input  logic wr_en,
  input  logic wr_val,
  output logic flag
);
  // Set beats acknowledge-clear, which beats a software write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_req) flag <= 1'b1;
    else if (clr_ack) flag <= 1'b0;
    else if (wr_en)   flag <= wr_val;
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_gie,
  input  logic [NSRC-1:0] wr_en_bits,
  input  logic            ack_fire,
  output logic            gie,
  output logic [NSRC-1:0] src_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gie <= 1'b0;
    else if (ack_fire) gie <= 1'b0;
    else if (wr_en)    gie <= wr_gie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     src_en <= '0;
    else if (wr_en) src_en <= wr_en_bits;
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int NSRC     = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic [NSRC-1:0]  pend,
  output logic [NSRC-1:0]  sel_oh,
  output logic [VEC_W-1:0] vector
);
  import irq_pkg::*;

  logic [31:0] iso;

  always_comb begin
    iso    = lowest_one(32'(pend));
    sel_oh = iso[NSRC-1:0];
    vector = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel_oh[i])
        vector = VEC_W'(vec_addr(i, VEC_BASE, VEC_STEP));
    end
  end
endmodule

// File: rtl/irq_guard_ctrl.sv
module irq_guard_ctrl #(
  parameter int NSRC     = 3,
  parameter int DATA_W   = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              stack_full,
  input  logic              irq_ack,
  output logic              irq_take,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              wake
);
  localparam int EN_LSB   = 1;
  localparam int FLAG_LSB = EN_LSB + NSRC;

  logic            gie;
  logic [NSRC-1:0] src_en;
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] sel_oh;
  logic            ack_fire;

  assign pend     = flags & src_en;
  assign wake     = |pend;
  assign irq_take = gie & wake & ~stack_full;
  assign ack_fire = irq_ack & irq_take;

  irq_enable_reg #(.NSRC(NSRC)) u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_we),
    .wr_gie     (reg_wdata[0]),
    .wr_en_bits (reg_wdata[EN_LSB +: NSRC]),
    .ack_fire   (ack_fire),
    .gie        (gie),
    .src_en     (src_en)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    irq_flag_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (src_req[i]),
      .clr_ack (ack_fire & sel_oh[i]),
      .wr_en   (reg_we),
      .wr_val  (reg_wdata[FLAG_LSB + i]),
      .flag    (flags[i])
    );
  end

  irq_prio_sel #(
    .NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_prio (
    .pend   (pend),
    .sel_oh (sel_oh),
    .vector (irq_vector)
  );

  always_comb begin
    reg_rdata                      = '0;
    reg_rdata[0]                   = gie;
    reg_rdata[EN_LSB +: NSRC]      = src_en;
    reg_rdata[FLAG_LSB +: NSRC]    = flags;
  end
endmodule

// File: rtl/irq_guard_chk.sv
module irq_guard_chk #(
  parameter int NSRC   = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_req,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              stack_full,
  input logic              irq_ack,
  input logic              irq_take,
  input logic              wake,
  input logic              ack_fire,
  input logic [NSRC-1:0]   sel_oh
);
  localparam int FLAG_LSB = 1 + NSRC;

  p_take_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (reg_rdata[0] && !stack_full));

  p_full_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stack_full) && wake && reg_rdata[0]) |-> irq_take);

  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh));

  p_ack_clears_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !reg_rdata[0]);

  p_ack_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_take && !reg_we && src_req == '0) |=> $stable(reg_rdata));

  p_take_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> wake);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    p_src_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      src_req[i] |=> reg_rdata[FLAG_LSB + i]);
  end
endmodule

bind irq_guard_ctrl irq_guard_chk #(.NSRC(NSRC), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_req    (src_req),
  .reg_we     (reg_we),
  .reg_rdata  (reg_rdata),
  .stack_full (stack_full),
  .irq_ack    (irq_ack),
  .irq_take   (irq_take),
  .wake       (wake),
  .ack_fire   (ack_fire),
  .sel_oh     (sel_oh)
);

// File: tb/tb_irq_guard_ctrl.sv
module tb_irq_guard_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_req = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       stack_full = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq_take;
  logic [7:0] irq_vector;
  logic       wake;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_guard_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stack_full(stack_full),
    .irq_ack(irq_ack), .irq_take(irq_take), .irq_vector(irq_vector),
    .wake(wake)
  );

  // {wdata, stack_full, exp_take, exp_vec, exp_wake}
  localparam int NROW = 11;
  localparam logic [18:0] TABLE [NROW] = '{
    {8'h00, 1'b0, 1'b0, 8'h00, 1'b0},
    {8'h13, 1'b0, 1'b1, 8'h04, 1'b1},
    {8'h25, 1'b0, 1'b1, 8'h08, 1'b1},
    {8'h49, 1'b0, 1'b1, 8'h0C, 1'b1},
    {8'h7F, 1'b0, 1'b1, 8'h04, 1'b1},
    {8'h6D, 1'b0, 1'b1, 8'h08, 1'b1},
    {8'h7D, 1'b0, 1'b1, 8'h08, 1'b1},
    {8'h7E, 1'b0, 1'b0, 8'h04, 1'b1},
    {8'h13, 1'b1, 1'b0, 8'h04, 1'b1},
    {8'h71, 1'b0, 1'b0, 8'h00, 1'b0},
    {8'hFF, 1'b1, 1'b0, 8'h04, 1'b1}
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive after the falling edge, let one rising edge pass, sample 1 ns later.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1'b1; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #5;
    check("R1", "rdata in reset", reg_rdata, 8'h00);
    check("R1", "take in reset", {7'b0, irq_take}, 8'h00);
    check("R1", "wake in reset", {7'b0, wake}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    step();
    check("R1", "rdata after reset", reg_rdata, 8'h00);

    // Table walk: R2 layout, R4 take, R5 vector, R9 wake
    for (int k = 0; k < NROW; k++) begin
      logic [7:0] wd, ev;
      logic sf, et, ew;
      {wd, sf, et, ev, ew} = TABLE[k];
      wr(wd);
      stack_full = sf;
      #1;
      check("R2", $sformatf("row %0d rdata", k), reg_rdata, wd & 8'h7F);
      check("R4", $sformatf("row %0d take", k), {7'b0, irq_take}, {7'b0, et});
      check("R5", $sformatf("row %0d vector", k), irq_vector, ev);
      check("R9", $sformatf("row %0d wake", k), {7'b0, wake}, {7'b0, ew});
      stack_full = 1'b0;
    end

    // R3: a source strobe sets its flag with everything disabled
    wr(8'h00);
    src_req = 3'b001; step(); src_req = '0;
    check("R3", "ext flag set, gie off", reg_rdata, 8'h10);
    check("R9", "no wake without enable", {7'b0, wake}, 8'h00);
    src_req = 3'b110; step(); src_req = '0;
    check("R3", "tmr and adc flags set", reg_rdata, 8'h70);

    // R6: acknowledge clears master enable and ext flag only
    wr(8'h7F);
    check("R5", "ext wins", irq_vector, 8'h04);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    check("R6", "ack clears gie and ext flag", reg_rdata, 8'h6E);
    check("R6", "take low after ack", {7'b0, irq_take}, 8'h00);
    check("R9", "wake stays without gie", {7'b0, wake}, 8'h01);

    // R11: re-enable, walk priority downward
    wr(8'h6F);
    check("R11", "timer offered", {irq_take, irq_vector[6:0]}, 8'h88);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    check("R6", "ack clears tmr", reg_rdata, 8'h4E);
    wr(8'h4F);
    check("R11", "adc offered", {irq_take, irq_vector[6:0]}, 8'h8C);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    check("R6", "ack clears adc", reg_rdata, 8'h0E);

    // R7: acknowledge without offer is ignored
    wr(8'h7E);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    check("R7", "ack with gie clear ignored", reg_rdata, 8'h7E);

    // R8: stack full holds off, release offers at once
    wr(8'h13);
    stack_full = 1'b1; #1;
    check("R8", "take held off", {7'b0, irq_take}, 8'h00);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    check("R7", "ack while full ignored", reg_rdata, 8'h13);
    check("R8", "still held after a cycle", {7'b0, irq_take}, 8'h00);
    stack_full = 1'b0; #1;
    check("R8", "take on release", {irq_take, irq_vector[6:0]}, 8'h84);

    // R10: set beats clear from ack and from write
    irq_ack = 1'b1; src_req = 3'b001; step(); irq_ack = 1'b0; src_req = '0;
    check("R10", "src beats ack clear", reg_rdata, 8'h12);
    reg_we = 1'b1; reg_wdata = 8'h00; src_req = 3'b010;
    step();
    reg_we = 1'b0; src_req = '0;
    check("R10", "src beats write clear", reg_rdata, 8'h20);

    // R6 priority over write for the master enable
    wr(8'h13);
    reg_we = 1'b1; reg_wdata = 8'h03; irq_ack = 1'b1;
    step();
    reg_we = 1'b0; irq_ack = 1'b0;
    check("R6", "ack beats write on gie", reg_rdata, 8'h02);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule